// File: doc/BRIEF.md
# Clock Trim Stepping Sequencer

This block walks a 3-bit signed clock trim setting from its present value to a new target, one least-significant step at a time. The target is the top three bits of a configuration byte. After each step the trim value is written out, and then the link is resynchronized. A resynchronization is a reinitialize request followed by an initialize (baud-learning) request. Each request is held until its acknowledge comes back. Moving the trim in single steps keeps the serial link recoverable at every point of the change.

A controller pulses `start_i` with the configuration byte and the trim value now in use. The sequencer runs on its own from there. It raises `busy_o` while it works and pulses `done_o` once the trim equals the target. The oscillator, the command transport and the memory that supplies the byte all sit outside the block.

Top module: `clk_trim_stepper`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `trim_wr_o`, `reinit_req_o` and `init_req_o` are all low.
- R2: When a start is accepted, the target is `cfg_byte_i[7:5]` and the starting value is `trim_cur_i`. Both are read as 3-bit two's complement (100 = -4 through 011 = +3). The last value written equals the target.
- R3: Each write, a one-cycle `trim_wr_o` pulse with its value on `trim_wr_val_o`, differs from the previous value by exactly one. The step is +1 when the target is greater in signed order and -1 when it is smaller. The number of writes equals the signed distance from start to target.
- R4: The cycle after each write, `reinit_req_o` rises. It stays high until `reinit_ack_i` is sampled high.
- R5: The cycle after the reinitialize acknowledge, `init_req_o` rises. It stays high until `init_ack_i` is sampled high. No further write happens before that acknowledge.
- R6: `reinit_req_o` and `init_req_o` are never high together. An acknowledge that arrives while its own request is low has no effect.
- R7: If the starting value already equals the target, `done_o` pulses two cycles after the start cycle. In that case there are no writes and no requests.
- R8: `busy_o` is high from the cycle after an accepted start until `done_o` rises. `done_o` is a one-cycle pulse and rises in the cycle `busy_o` falls.
- R9: A start pulse that arrives while `busy_o` is high is ignored. Its byte and trim value do not alter the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse |
| cfg_byte_i | input | 8 | Configuration byte; top three bits are the target trim |
| trim_cur_i | input | 3 | Trim value in use when the start is accepted |
| trim_wr_o | output | 1 | One-cycle trim write strobe |
| trim_wr_val_o | output | 3 | Trim value to write |
| reinit_req_o | output | 1 | Reinitialize command request |
| reinit_ack_i | input | 1 | Reinitialize done |
| init_req_o | output | 1 | Initialize (baud-learning) command request |
| init_ack_i | input | 1 | Initialize done |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Several cases are hard to reach from the ports.

- **Stray acknowledges.** The bench raises the initialize acknowledge while only the reinitialize request is open, and the reverse. It then checks that neither request moves early.
- **Start while busy.** A second start with a different byte and trim value is pulsed in the middle of a walk. The bench checks that the original target is still reached with the original number of writes.
- **Full range and sign crossing.** Walks cover both extreme spans, -4 to +3 and +3 to -4, and one that crosses zero. These expose an unsigned comparison or wrap-around.

// File: rtl/cts_pkg.sv
package cts_pkg;

    localparam int TRIM_W = 3;

    typedef logic signed [TRIM_W-1:0] trim_t;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_CHECK = 2'd1,
        SQ_WRITE = 2'd2,
        SQ_WAIT  = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        RS_IDLE   = 2'd0,
        RS_REINIT = 2'd1,
        RS_INIT   = 2'd2
    } rs_state_e;

    typedef struct packed {
        logic  equal;
        trim_t next;
    } step_s;

    // One signed step from cur toward tgt.
    function automatic step_s step_toward(trim_t cur, trim_t tgt);
        step_s s;
        s.equal = (cur == tgt);
        if (s.equal)
            s.next = cur;
        else if (cur < tgt)
            s.next = cur + trim_t'(1);
        else
            s.next = cur - trim_t'(1);
        return s;
    endfunction

endpackage

// File: rtl/cts_target_pick.sv
module cts_target_pick
    import cts_pkg::*;
#(
    parameter int CFG_W = 8
) (
    input  logic [CFG_W-1:0] cfg_i,
    output trim_t            target_o
);
    localparam int TRIM_LSB = CFG_W - TRIM_W;

    logic unused_low;

    assign target_o   = trim_t'(cfg_i[CFG_W-1:TRIM_LSB]);
    assign unused_low = ^cfg_i[TRIM_LSB-1:0];
endmodule

// File: rtl/cts_stepper.sv
module cts_stepper
    import cts_pkg::*;
(
    input  trim_t cur_i,
    input  trim_t tgt_i,
    output step_s step_o
);
    assign step_o = step_toward(cur_i, tgt_i);
endmodule

// File: rtl/cts_resync.sv
module cts_resync
    import cts_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic go_i,
    input  logic reinit_ack_i,
    input  logic init_ack_i,
    output logic reinit_req_o,
    output logic init_req_o,
    output logic fin_o
);
    rs_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        case (st_q)
            RS_IDLE:   if (go_i)         st_d = RS_REINIT;
            RS_REINIT: if (reinit_ack_i) st_d = RS_INIT;
            RS_INIT:   if (init_ack_i)   st_d = RS_IDLE;
            default:                     st_d = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= RS_IDLE;
        else     st_q <= st_d;
    end

    assign reinit_req_o = (st_q == RS_REINIT);
    assign init_req_o   = (st_q == RS_INIT);
    assign fin_o        = (st_q == RS_INIT) && init_ack_i;
endmodule

// File: rtl/clk_trim_stepper.sv
module clk_trim_stepper
    import cts_pkg::*;
#(
    parameter int CFG_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [CFG_W-1:0]  cfg_byte_i,
    input  logic [TRIM_W-1:0] trim_cur_i,
    output logic              trim_wr_o,
    output logic [TRIM_W-1:0] trim_wr_val_o,
    output logic              reinit_req_o,
    input  logic              reinit_ack_i,
    output logic              init_req_o,
    input  logic              init_ack_i,
    output logic              busy_o,
    output logic              done_o
);
    seq_state_e st_q, st_d;
    trim_t      tgt_q, work_q, tgt_in;
    step_s      step;
    logic       accept, rs_go, rs_fin, done_q;

    cts_target_pick #(.CFG_W(CFG_W)) u_pick (
        .cfg_i    (cfg_byte_i),
        .target_o (tgt_in)
    );

    cts_stepper u_step (
        .cur_i  (work_q),
        .tgt_i  (tgt_q),
        .step_o (step)
    );

    cts_resync u_rs (
        .clk          (clk),
        .rst          (rst),
        .go_i         (rs_go),
        .reinit_ack_i (reinit_ack_i),
        .init_ack_i   (init_ack_i),
        .reinit_req_o (reinit_req_o),
        .init_req_o   (init_req_o),
        .fin_o        (rs_fin)
    );

    assign accept = start_i && (st_q == SQ_IDLE);
    assign rs_go  = (st_q == SQ_WRITE);

    always_comb begin
        st_d = st_q;
        case (st_q)
            SQ_IDLE:  if (accept) st_d = SQ_CHECK;
            SQ_CHECK: st_d = step.equal ? SQ_IDLE : SQ_WRITE;
            SQ_WRITE: st_d = SQ_WAIT;
            SQ_WAIT:  if (rs_fin) st_d = SQ_CHECK;
            default:  st_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SQ_IDLE;
            tgt_q  <= '0;
            work_q <= '0;
            done_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            done_q <= (st_q == SQ_CHECK) && step.equal;
            if (accept) begin
                tgt_q  <= tgt_in;
                work_q <= trim_t'(trim_cur_i);
            end else if ((st_q == SQ_CHECK) && !step.equal) begin
                work_q <= step.next;
            end
        end
    end

    assign trim_wr_o     = (st_q == SQ_WRITE);
    assign trim_wr_val_o = work_q;
    assign busy_o        = (st_q != SQ_IDLE);
    assign done_o        = done_q;
endmodule

// File: rtl/cts_checker.sv
module cts_checker (
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic [2:0] trim_cur_i,
    input logic       trim_wr_o,
    input logic [2:0] trim_wr_val_o,
    input logic       reinit_req_o,
    input logic       reinit_ack_i,
    input logic       init_req_o,
    input logic       init_ack_i,
    input logic       busy_o,
    input logic       done_o
);
    logic signed [3:0] last_q;
    logic signed [3:0] diff;

    always_ff @(posedge clk) begin
        if (rst)
            last_q <= '0;
        else if (start_i && !busy_o)
            last_q <= 4'(signed'(trim_cur_i));
        else if (trim_wr_o)
            last_q <= 4'(signed'(trim_wr_val_o));
    end

    assign diff = 4'(signed'(trim_wr_val_o)) - last_q;

    // R3: each write moves exactly one LSB
    a_r3_unit_step: assert property (@(posedge clk) disable iff (rst)
        trim_wr_o |-> (diff == 4'sd1 || diff == -4'sd1));

    // R4: write is followed by reinitialize request
    a_r4_reinit_after_write: assert property (@(posedge clk) disable iff (rst)
        trim_wr_o |=> reinit_req_o);

    // R4: request held until acknowledged
    a_r4_reinit_hold: assert property (@(posedge clk) disable iff (rst)
        (reinit_req_o && !reinit_ack_i) |=> reinit_req_o);

    // R5: initialize follows reinitialize acknowledge
    a_r5_init_after_reinit: assert property (@(posedge clk) disable iff (rst)
        (reinit_req_o && reinit_ack_i) |=> init_req_o);

    // R5: initialize held until acknowledged
    a_r5_init_hold: assert property (@(posedge clk) disable iff (rst)
        (init_req_o && !init_ack_i) |=> init_req_o);

    // R6: requests exclusive
    a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(reinit_req_o && init_req_o));

    // R8: done is one cycle and coincides with idle
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);
endmodule

bind clk_trim_stepper cts_checker u_chk (.*);

// File: tb/tb_clk_trim_stepper.sv
`timescale 1ns/1ps
module tb_clk_trim_stepper;
    logic       clk = 1'b0;
    logic       rst;
    logic       start_i;
    logic [7:0] cfg_byte_i;
    logic [2:0] trim_cur_i;
    logic       trim_wr_o;
    logic [2:0] trim_wr_val_o;
    logic       reinit_req_o, reinit_ack_i;
    logic       init_req_o, init_ack_i;
    logic       busy_o, done_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    clk_trim_stepper dut (
        .clk(clk), .rst(rst), .start_i(start_i), .cfg_byte_i(cfg_byte_i),
        .trim_cur_i(trim_cur_i), .trim_wr_o(trim_wr_o), .trim_wr_val_o(trim_wr_val_o),
        .reinit_req_o(reinit_req_o), .reinit_ack_i(reinit_ack_i),
        .init_req_o(init_req_o), .init_ack_i(init_ack_i),
        .busy_o(busy_o), .done_o(done_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int s3(input logic [2:0] v);
        return int'(signed'(v));
    endfunction

    task automatic t_reset();
        rst = 1'b1; start_i = 1'b0; cfg_byte_i = '0; trim_cur_i = '0;
        reinit_ack_i = 1'b0; init_ack_i = 1'b0;
        tick(); tick();
        rst = 1'b0;
        tick();
        // R1: quiet after reset
        check({busy_o, done_o, trim_wr_o, reinit_req_o, init_req_o} == 5'b0, "R1",
              int'({busy_o, done_o, trim_wr_o, reinit_req_o, init_req_o}), 0);
    endtask

    task automatic t_equal();
        start_i = 1'b1; cfg_byte_i = 8'b010_10101; trim_cur_i = 3'b010;
        tick();
        start_i = 1'b0;
        check(busy_o && !done_o, "R8 busy after start", int'(busy_o), 1);
        tick();
        // R7: done with no activity
        check(done_o && !busy_o, "R7 done timing", int'(done_o), 1);
        check(!trim_wr_o && !reinit_req_o && !init_req_o, "R7 no activity", int'(trim_wr_o), 0);
        tick();
        check(!done_o, "R8 done pulse", int'(done_o), 0);
    endtask

    task automatic walk(input logic [2:0] cur, input logic [7:0] cfg, input int lat,
                        input bit poke, input bit inject);
        int tgt = s3(cfg[7:5]);
        int last = s3(cur);
        int want = (tgt > last) ? tgt - last : last - tgt;
        int dir = (tgt > last) ? 1 : -1;
        int writes = 0;
        int phase = 0;
        int cnt = 0;
        bit got_done = 1'b0;
        start_i = 1'b1; cfg_byte_i = cfg; trim_cur_i = cur;
        tick();
        start_i = 1'b0;
        check(busy_o, "R8 busy after start", int'(busy_o), 1);
        for (int cyc = 0; cyc < 400; cyc++) begin
            reinit_ack_i = 1'b0; init_ack_i = 1'b0; start_i = 1'b0;
            if (done_o) begin got_done = 1'b1; break; end
            if (reinit_req_o && init_req_o)
                check(1'b0, "R6 both requests", 1, 0);
            if (inject && cyc == 4) begin
                // R9: start while busy must be ignored
                start_i = 1'b1; cfg_byte_i = 8'b011_00000; trim_cur_i = 3'b100;
            end
            if (trim_wr_o) begin
                check(phase == 0, "R5 write before init ack", phase, 0);
                check(s3(trim_wr_val_o) == last + dir, "R3 step value",
                      s3(trim_wr_val_o), last + dir);
                last = s3(trim_wr_val_o);
                writes++;
                phase = 1; cnt = 0;
            end else if (phase == 1) begin
                check(reinit_req_o && !init_req_o, "R4 reinit held", int'(reinit_req_o), 1);
                cnt++;
                if (cnt >= lat) begin reinit_ack_i = 1'b1; phase = 2; cnt = 0; end
                else if (poke) init_ack_i = 1'b1;
            end else if (phase == 2) begin
                check(init_req_o && !reinit_req_o, "R5 init held", int'(init_req_o), 1);
                cnt++;
                if (cnt >= lat) begin init_ack_i = 1'b1; phase = 3; end
                else if (poke) reinit_ack_i = 1'b1;
            end else if (phase == 3) begin
                check(!init_req_o && !reinit_req_o, "R6 requests closed", int'(init_req_o), 0);
                phase = 0;
            end
            tick();
        end
        reinit_ack_i = 1'b0; init_ack_i = 1'b0; start_i = 1'b0;
        check(got_done && !busy_o, "R8 done with busy low", int'(got_done), 1);
        check(writes == want, "R3 write count", writes, want);
        check(last == tgt, "R2 final target", last, tgt);
        tick();
        check(!done_o, "R8 done pulse", int'(done_o), 0);
    endtask

    initial begin
        t_reset();
        t_equal();
        walk(3'b000, 8'b010_00111, 1, 1'b0, 1'b0);  // R2 R3 R4 R5: 0 -> 2
        walk(3'b100, 8'b011_00000, 3, 1'b1, 1'b0);  // R3 R6: -4 -> +3
        walk(3'b011, 8'b100_11111, 2, 1'b1, 1'b0);  // R3 R6: +3 -> -4
        walk(3'b111, 8'b001_01010, 4, 1'b0, 1'b0);  // R3: cross zero
        walk(3'b000, 8'b110_00001, 2, 1'b0, 1'b1);  // R9: start while busy
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 100000; i++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule